// File: doc/BRIEF.md
# Topology-Aware Spare Core Selector

When a processing core checkstops, this block chooses a dormant spare core to take over its work. The system has up to four boards joined by a pair of counter-rotating rings, and each board carries several cores. The block ranks the free spares by how close they are to the failed core. A spare on the same board is the first choice. A spare on a board that is the failed board's direct ring neighbour comes next. Any other spare comes last. Within one rank the lowest core index wins.

A request brings the failing core index, a flag that marks a dual-core chip, the spare bitmap, the board index of every core, and the present-board mask. The block captures all of these when it accepts the request. A dual-core failure takes the sibling core down as well, so the block makes a second selection for that sibling in the next cycle. The second selection works from the bitmap as updated by the first grant. Each selection gives either a grant pulse with the chosen core index, or a no-spare pulse that tells software to start application-level recovery and raise a service request. The updated bitmap is always visible, so the caller can return it with its next request.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle. A caller may hold `req_valid` and its payload for as long as it likes, and the request is taken on the first rising edge where both signals are high. No other port carries back-pressure: the result pulses cannot be stalled.

Top module: `spare_core_selector`

## Requirements
- R1: When a spare core (its `spare_map` bit set) sits on a present board equal to the board of the core being replaced, the grant goes to such a core.
- R2: When the same board has no spare, the grant goes to a spare on a present board that is ring-adjacent to the failing board. Adjacency is board 0:{2,3}, 1:{2,3}, 2:{0,1}, 3:{0,1}.
- R3: When neither of those exists, the grant goes to any spare on any present board.
- R4: When no candidate exists at all, `no_spare` pulses for one cycle, `grant_valid` stays low, and the bitmap is unchanged.
- R5: Among candidates of the same rank, the lowest core index is chosen. `grant_core` reads 0 in every cycle where `grant_valid` is low.
- R6: A core whose board (its 2-bit field `core_board[2c+1:2c]`) is clear in `board_present` is never granted.
- R7: With `req_dual` set, the sibling core is `req_fail_core ^ 1`. Its selection uses the sibling's own board and produces a second result one cycle after the first. `done` pulses together with the last result of a request.
- R8: A granted core's bit is cleared in `spare_map_out` in the same cycle that the grant is shown. A second selection therefore never reuses it.
- R9: The failing core, and its sibling when `req_dual` is set, are removed from the captured bitmap and are never granted.
- R10: `req_ready` is high exactly when the block is idle. The first result appears in the cycle after the accepting edge. `req_ready` returns high in the same cycle as `done`.
- R11: After reset `req_ready` is 1, and `grant_valid`, `grant_core`, `no_spare`, `done` and `spare_map_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_fail_core | input | IW | Index of the checkstopped core |
| req_dual | input | 1 | Failed chip is dual-core, so the sibling must be replaced too |
| spare_map | input | NUM_CORES | Spare availability, one bit per core |
| core_board | input | 2*NUM_CORES | Board index of each core, 2 bits per core |
| board_present | input | 4 | Present-board mask |
| grant_valid | output | 1 | One-cycle pulse: a spare was chosen |
| grant_core | output | IW | Index of the chosen spare |
| no_spare | output | 1 | One-cycle pulse: no spare left, software fallback needed |
| done | output | 1 | One-cycle pulse with the last result of a request |
| spare_map_out | output | NUM_CORES | Captured bitmap after the grants so far |

## Verification
A single request produces its only result, together with `done`, in the cycle after the accepting edge. A dual request produces its first result in that cycle and its second result, with `done`, one cycle later. `req_ready` rises again in the `done` cycle. The bench reference model steps once per rising edge from the same inputs and predicts every output for the following cycle. The bench compares the design's outputs against that prediction at each falling edge, so every comparison lands in the cycle where the result is due. Directed cases cover each rank, absent boards, exclusion of the failing cores and back-to-back requests, and a long pseudo-random run mixes board layouts.

// File: rtl/spsel_pkg.sv
package spsel_pkg;

  localparam int BOARD_W = 2;
  localparam int BOARDS  = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } sel_state_e;

  // Ring order is 0,2,1,3; the ring position of board b is {b[0],b[1]}.
  function automatic logic [1:0] ring_pos(input logic [BOARD_W-1:0] b);
    return {b[0], b[1]};
  endfunction

  function automatic logic ring_adjacent(input logic [BOARD_W-1:0] a,
                                         input logic [BOARD_W-1:0] b);
    logic [1:0] d;
    d = ring_pos(a) - ring_pos(b);
    return (d == 2'd1) || (d == 2'd3);
  endfunction

endpackage

// File: rtl/spsel_tier_mask.sv
module spsel_tier_mask
  import spsel_pkg::*;
#(
  parameter int NUM_CORES = 16
) (
  input  logic [NUM_CORES-1:0]         avail,
  input  logic [NUM_CORES*BOARD_W-1:0] core_board,
  input  logic [BOARDS-1:0]            present,
  input  logic [BOARD_W-1:0]           fail_board,
  output logic [NUM_CORES-1:0]         same_m,
  output logic [NUM_CORES-1:0]         adj_m,
  output logic [NUM_CORES-1:0]         any_m
);

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
    logic [BOARD_W-1:0] cb;
    logic               live;
    assign cb         = core_board[gi*BOARD_W +: BOARD_W];
    assign live       = avail[gi] & present[cb];
    assign same_m[gi] = live & (cb == fail_board);
    assign adj_m[gi]  = live & ring_adjacent(fail_board, cb);
    assign any_m[gi]  = live;
  end

endmodule

// File: rtl/spsel_lowest.sv
module spsel_lowest #(
  parameter int W  = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/spsel_picker.sv
module spsel_picker
  import spsel_pkg::*;
#(
  parameter int NUM_CORES = 16,
  localparam int IW = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES-1:0]         avail,
  input  logic [NUM_CORES*BOARD_W-1:0] core_board,
  input  logic [BOARDS-1:0]            present,
  input  logic [BOARD_W-1:0]           fail_board,
  output logic                         found,
  output logic [IW-1:0]                pick,
  output logic                         same_found
);

  localparam int TIERS = 3;

  logic [NUM_CORES-1:0] tier_m [TIERS];
  logic [TIERS-1:0]     tier_hit;
  logic [IW-1:0]        tier_idx [TIERS];

  spsel_tier_mask #(.NUM_CORES(NUM_CORES)) u_mask (
    .avail      (avail),
    .core_board (core_board),
    .present    (present),
    .fail_board (fail_board),
    .same_m     (tier_m[0]),
    .adj_m      (tier_m[1]),
    .any_m      (tier_m[2])
  );

  for (genvar gt = 0; gt < TIERS; gt++) begin : g_tier
    spsel_lowest #(.W(NUM_CORES)) u_low (
      .vec   (tier_m[gt]),
      .found (tier_hit[gt]),
      .idx   (tier_idx[gt])
    );
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int t = TIERS - 1; t >= 0; t--) begin
      if (tier_hit[t]) begin
        found = 1'b1;
        pick  = tier_idx[t];
      end
    end
  end

  assign same_found = tier_hit[0];

endmodule

// File: rtl/spare_core_selector.sv
module spare_core_selector
  import spsel_pkg::*;
#(
  parameter int NUM_CORES = 16,
  localparam int IW = $clog2(NUM_CORES),
  localparam int BMW = NUM_CORES * BOARD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [IW-1:0]        req_fail_core,
  input  logic                 req_dual,
  input  logic [NUM_CORES-1:0] spare_map,
  input  logic [BMW-1:0]       core_board,
  input  logic [BOARDS-1:0]    board_present,
  output logic                 grant_valid,
  output logic [IW-1:0]        grant_core,
  output logic                 no_spare,
  output logic                 done,
  output logic [NUM_CORES-1:0] spare_map_out
);

  sel_state_e           state_q;
  logic [NUM_CORES-1:0] avail_q;
  logic [BMW-1:0]       board_q;
  logic [BOARDS-1:0]    present_q;
  logic [IW-1:0]        tgt_q;
  logic                 dual_q;

  logic                 accept;
  logic [NUM_CORES-1:0] excl;
  logic [BOARD_W-1:0]   tgt_board;
  logic                 found;
  logic [IW-1:0]        pick;
  logic                 same_found;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign tgt_board = board_q[32'(tgt_q)*BOARD_W +: BOARD_W];

  always_comb begin
    excl = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (IW'(c) == req_fail_core) excl[c] = 1'b1;
      if (req_dual && (IW'(c) == (req_fail_core ^ IW'(1)))) excl[c] = 1'b1;
    end
  end

  spsel_picker #(.NUM_CORES(NUM_CORES)) u_pick (
    .avail      (avail_q),
    .core_board (board_q),
    .present    (present_q),
    .fail_board (tgt_board),
    .found      (found),
    .pick       (pick),
    .same_found (same_found)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      avail_q     <= '0;
      board_q     <= '0;
      present_q   <= '0;
      tgt_q       <= '0;
      dual_q      <= 1'b0;
      grant_valid <= 1'b0;
      grant_core  <= '0;
      no_spare    <= 1'b0;
      done        <= 1'b0;
    end else begin
      grant_valid <= 1'b0;
      grant_core  <= '0;
      no_spare    <= 1'b0;
      done        <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            avail_q   <= spare_map & ~excl;
            board_q   <= core_board;
            present_q <= board_present;
            tgt_q     <= req_fail_core;
            dual_q    <= req_dual;
            state_q   <= ST_FIRST;
          end
        end
        ST_FIRST, ST_SECOND: begin
          if (found) begin
            grant_valid   <= 1'b1;
            grant_core    <= pick;
            avail_q[pick] <= 1'b0;
          end else begin
            no_spare <= 1'b1;
          end
          if (state_q == ST_FIRST && dual_q) begin
            tgt_q   <= tgt_q ^ IW'(1);
            state_q <= ST_SECOND;
          end else begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spare_map_out = avail_q;

  // R8
  grant_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !spare_map_out[grant_core]);

  // R8
  grant_consumes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones($past(avail_q)) == $countones(avail_q) + 1));

  // R4
  no_spare_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_spare |-> (!grant_valid && $stable(avail_q)));

  // R10
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  second_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SECOND) |=> (done && req_ready));

  // R1
  same_board_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && same_found) |=>
      (grant_valid && (board_q[32'(grant_core)*BOARD_W +: BOARD_W] == $past(tgt_board))));

  // R6
  present_board_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> present_q[board_q[32'(grant_core)*BOARD_W +: BOARD_W]]);

endmodule

// File: tb/spare_core_selector_tb.sv
module spare_core_selector_tb;

  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [IW-1:0] req_fail_core = '0;
  logic          req_dual = 1'b0;
  logic [N-1:0]  spare_map = '0;
  logic [2*N-1:0] core_board = '0;
  logic [3:0]    board_present = 4'hF;
  logic          grant_valid;
  logic [IW-1:0] grant_core;
  logic          no_spare;
  logic          done;
  logic [N-1:0]  spare_map_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_tag = "R11";

  always #2.5 clk = ~clk;

  spare_core_selector #(.NUM_CORES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fail_core(req_fail_core), .req_dual(req_dual), .spare_map(spare_map),
    .core_board(core_board), .board_present(board_present),
    .grant_valid(grant_valid), .grant_core(grant_core), .no_spare(no_spare),
    .done(done), .spare_map_out(spare_map_out)
  );

  // Behavioural reference model
  int        m_state;
  bit [N-1:0] m_avail;
  int        m_brd [N];
  bit [3:0]  m_pres;
  int        m_tgt;
  bit        m_dual;
  bit        e_gv, e_ns, e_done;
  int        e_core;

  function automatic bit adj(int a, int b);
    case (a)
      0, 1: return (b == 2) || (b == 3);
      default: return (b == 0) || (b == 1);
    endcase
  endfunction

  function automatic int choose(int tgt);
    int fb = m_brd[tgt];
    for (int tier = 0; tier < 3; tier++)
      for (int c = 0; c < N; c++)
        if (m_avail[c] && m_pres[m_brd[c]]) begin
          if (tier == 0 && m_brd[c] == fb) return c;
          if (tier == 1 && adj(fb, m_brd[c])) return c;
          if (tier == 2) return c;
        end
    return -1;
  endfunction

  task automatic model_select();
    int c = choose(m_tgt);
    if (c >= 0) begin
      e_gv = 1; e_core = c; m_avail[c] = 0;
    end else e_ns = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_avail = '0; e_gv = 0; e_ns = 0; e_done = 0; e_core = 0;
    end else begin
      e_gv = 0; e_ns = 0; e_done = 0; e_core = 0;
      case (m_state)
        0: if (req_valid) begin
             m_avail = spare_map;
             m_avail[req_fail_core] = 0;
             if (req_dual) m_avail[req_fail_core ^ 1] = 0;
             for (int c = 0; c < N; c++) m_brd[c] = int'(core_board[2*c +: 2]);
             m_pres = board_present;
             m_tgt = int'(req_fail_core);
             m_dual = req_dual;
             m_state = 1;
           end
        1: begin
             model_select();
             if (m_dual) begin m_tgt = m_tgt ^ 1; m_state = 2; end
             else begin e_done = 1; m_state = 0; end
           end
        default: begin
             model_select();
             e_done = 1; m_state = 0;
           end
      endcase
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_tag, "grant_valid", int'(grant_valid), int'(e_gv));
      chk(cur_tag, "grant_core", int'(grant_core), e_core);
      chk(cur_tag, "no_spare", int'(no_spare), int'(e_ns));
      chk("R7", "done", int'(done), int'(e_done));
      chk("R10", "req_ready", int'(req_ready), int'(m_state == 0));
      chk("R8", "spare_map_out", int'(spare_map_out), int'(m_avail));
    end
  end

  task automatic set_boards_linear();
    for (int c = 0; c < N; c++) core_board[2*c +: 2] = 2'(c / 4);
  endtask

  task automatic send(int fail, bit dual, logic [N-1:0] map, logic [3:0] pres);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_fail_core = IW'(fail); req_dual = dual; spare_map = map;
    board_present = pres; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    set_boards_linear();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "req_ready", int'(req_ready), 1);
    chk("R11", "grant_valid", int'(grant_valid), 0);
    chk("R11", "no_spare", int'(no_spare), 0);
    chk("R11", "done", int'(done), 0);
    chk("R11", "spare_map_out", int'(spare_map_out), 0);
    rst_n = 1'b1;

    cur_tag = "R1";  send(0, 0, 16'h020C, 4'hF);   // same board: core 2
    cur_tag = "R5";  send(5, 0, 16'h00C0, 4'hF);   // lowest of 6,7 -> 6
    cur_tag = "R2";  send(1, 0, 16'h2220, 4'hF);   // ring neighbour: core 9
    cur_tag = "R3";  send(0, 0, 16'h0040, 4'hF);   // any board: core 6
    cur_tag = "R4";  send(3, 0, 16'h0000, 4'hF);   // none
    cur_tag = "R6";  send(0, 0, 16'h0110, 4'hB);   // board 2 absent -> core 4
    cur_tag = "R6";  send(0, 0, 16'h0100, 4'hB);   // only absent spare -> none
    cur_tag = "R7";  send(4, 1, 16'h1040, 4'hF);   // 6 then 12
    cur_tag = "R9";  send(2, 1, 16'h008C, 4'hF);   // 2,3 excluded -> 7 then none
    cur_tag = "R8";  send(8, 1, 16'h0400, 4'hF);   // 10 then none

    // R10: back-to-back requests with valid held through the busy cycles
    cur_tag = "R10";
    @(negedge clk);
    req_fail_core = 4'd12; req_dual = 1'b1; spare_map = 16'hA000;
    board_present = 4'hF; req_valid = 1'b1;
    repeat (7) @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R5: mixed board layouts
    cur_tag = "R5";
    for (int it = 0; it < 300; it++) begin
      for (int c = 0; c < N; c++) core_board[2*c +: 2] = 2'($urandom_range(0, 3));
      send(int'($urandom_range(0, N - 1)), bit'($urandom_range(0, 1)),
           N'($urandom), 4'($urandom_range(1, 15)));
    end

    repeat (4) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule